// File: doc/BRIEF.md
# Set-Associative Read Cache

This block is a read-only cache with a 32-bit byte-address request port. It splits the request address into a tag, a set index and a block offset. It then compares the valid bit and stored tag of every way in the indexed set against the request tag, all in the same cycle. When one way matches, that way's line feeds the addressed word through a way multiplexer. When no way matches, the block issues one block-aligned read on a simple memory port, takes the block's words in ascending order and installs the whole line. It then answers the request from the refilled data.

The way that receives a refill is the lowest-numbered invalid way of the set. If every way of the set is valid, the way named by the replacement input is used instead. An external least-recently-used tracker supplies that input. The tracker sees the set being served on `query_set`, and it learns of every hit and every fill through a one-cycle use report. Only one request is in flight at a time, and the request port is ready only while the cache is idle.

Top module: `sa_read_cache`

## Requirements
- R1: With the default parameters (4 ways, SET_BITS=2, OFF_BITS=3), address bits [2:0] are the byte offset and bits [4:3] are the set index. Bits [31:5] are the tag, and bit 2 selects the 32-bit word within the 8-byte block.
- R2: A request hits when some way of its set holds a valid line whose tag equals the request tag. On a hit, `resp_valid` pulses for one cycle, two clock edges after the edge that accepted the request. It comes with `resp_hit`=1 and the stored word, and no memory read is issued.
- R3: A miss issues exactly one memory read whose address is the request address with the offset bits cleared. `mem_req_valid` and `mem_req_addr` are held until `mem_req_ready` is seen.
- R4: A refill takes exactly 2^(OFF_BITS-2) words in ascending address order, one per cycle in which `mem_resp_valid` is high. It installs the whole block, so a later request to any other word of that block hits.
- R5: On a miss, the refill goes into the lowest-numbered invalid way of the set. The other ways of the set keep their lines.
- R6: On a miss where every way of the set is valid, the refill replaces the way given by `repl_way` as sampled during the lookup. `query_set` shows the set index of the request being served.
- R7: Every hit and every fill pulses `use_valid` in the same cycle as `resp_valid`. The pulse carries the set in `use_set` and the way that was read or filled in `use_way`.
- R8: After reset, no line is valid, `req_ready` is 1, and `resp_valid`, `mem_req_valid` and `use_valid` are 0. `req_ready` is 1 only while no request is being served.
- R9: With empty lines, the byte-address sequence 4, 0, 8, 36, 0 gives miss, hit, miss, miss, hit, and the block holding 36 is placed in way 1 of set 0.
- R10: On a miss, `resp_valid` pulses with `resp_hit`=0 in the cycle after the edge that takes the last refill word. `resp_data` is the memory word at the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Cache idle, request accepted this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 if the response came from a hit |
| resp_data | output | 32 | Word at the request address |
| mem_req_valid | output | 1 | Block read request to memory |
| mem_req_addr | output | 32 | Block-aligned read address |
| mem_req_ready | input | 1 | Memory accepts the block read |
| mem_resp_valid | input | 1 | One refill word present |
| mem_resp_data | input | 32 | Refill word, ascending order |
| repl_way | input | WAY_W | Replacement victim for the set in `query_set` |
| query_set | output | SET_BITS | Set index of the request being served |
| use_valid | output | 1 | Use report strobe |
| use_set | output | SET_BITS | Set that was used |
| use_way | output | WAY_W | Way that was hit or filled |

## Verification
The hardest case to reach is a miss in a set whose ways are all valid, because only then does `repl_way` decide the victim. It is also the only case in which a line that was valid can be lost. The stimulus first fills set 0 with four distinct tags and forces an eviction of way 1. It then shows that the evicted block misses while the block in way 0 still hits. The random phase draws tags from a pool larger than the associativity and concentrates on a few sets, so that full-set evictions with random victims happen often. A bench model of valid bits and tags predicts every hit, every chosen way and every data word.

// File: rtl/sa_read_cache.sv
module sa_read_cache #(
  parameter int WAYS     = 4,
  parameter int SET_BITS = 2,
  parameter int OFF_BITS = 3,
  parameter int WAY_W    = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         req_addr,
  output logic                req_ready,
  output logic                resp_valid,
  output logic                resp_hit,
  output logic [31:0]         resp_data,
  output logic                mem_req_valid,
  output logic [31:0]         mem_req_addr,
  input  logic                mem_req_ready,
  input  logic                mem_resp_valid,
  input  logic [31:0]         mem_resp_data,
  input  logic [WAY_W-1:0]    repl_way,
  output logic [SET_BITS-1:0] query_set,
  output logic                use_valid,
  output logic [SET_BITS-1:0] use_set,
  output logic [WAY_W-1:0]    use_way
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int TAG_W  = 32 - SET_BITS - OFF_BITS;
  localparam int WOFF_W = OFF_BITS - 2;
  localparam int WPB    = 1 << WOFF_W;
  localparam int CNT_W  = (WOFF_W > 0) ? WOFF_W : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_MREQ, S_FILL} state_t;

  state_t                 state_q;
  logic [31:0]            addr_q;
  logic [WAYS-1:0]        valid_q [SETS];
  logic [TAG_W-1:0]       tag_q   [SETS][WAYS];
  logic [31:0]            line_q  [SETS][WAYS][WPB];
  logic [WAY_W-1:0]       fill_way_q;
  logic [CNT_W-1:0]       cnt_q;

  logic [SET_BITS-1:0]    set_w;
  logic [TAG_W-1:0]       tag_w;
  logic [CNT_W-1:0]       word_w;
  logic [WAYS-1:0]        hit_vec;
  logic [WAYS-1:0]        free_vec;
  logic [WAY_W-1:0]       hit_way;
  logic [WAY_W-1:0]       free_way;
  logic                   last_word;

  assign set_w = addr_q[OFF_BITS +: SET_BITS];
  assign tag_w = addr_q[31 -: TAG_W];

  generate
    if (WOFF_W > 0) begin : g_word
      assign word_w = addr_q[2 +: CNT_W];
    end else begin : g_noword
      assign word_w = '0;
    end
  endgenerate

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid_q[set_w][w] && (tag_q[set_w][w] == tag_w);
    end
  endgenerate

  assign free_vec = ~valid_q[set_w];

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

  assign last_word     = (cnt_q == CNT_W'(WPB - 1));
  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_MREQ);
  assign mem_req_addr  = {addr_q[31:OFF_BITS], {OFF_BITS{1'b0}}};
  assign query_set     = set_w;

  always_ff @(posedge clk) begin
    if (state_q == S_FILL && mem_resp_valid)
      line_q[set_w][fill_way_q][cnt_q] <= mem_resp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      fill_way_q <= '0;
      cnt_q      <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      use_valid  <= 1'b0;
      use_set    <= '0;
      use_way    <= '0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      resp_valid <= 1'b0;
      use_valid  <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          state_q <= S_LOOK;
        end
        S_LOOK: if (|hit_vec) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_data  <= line_q[set_w][hit_way][word_w];
          use_valid  <= 1'b1;
          use_set    <= set_w;
          use_way    <= hit_way;
          state_q    <= S_IDLE;
        end else begin
          fill_way_q <= (|free_vec) ? free_way : repl_way;
          cnt_q      <= '0;
          state_q    <= S_MREQ;
        end
        S_MREQ: if (mem_req_ready) state_q <= S_FILL;
        S_FILL: if (mem_resp_valid) begin
          if (cnt_q == word_w) resp_data <= mem_resp_data;
          cnt_q <= cnt_q + 1'b1;
          if (last_word) begin
            valid_q[set_w][fill_way_q] <= 1'b1;
            tag_q[set_w][fill_way_q]   <= tag_w;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            use_valid  <= 1'b1;
            use_set    <= set_w;
            use_way    <= fill_way_q;
            state_q    <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_read_cache_checker.sv
module sa_read_cache_checker #(
  parameter int OFF_BITS = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_hit,
  input logic        mem_req_valid,
  input logic [31:0] mem_req_addr,
  input logic        mem_req_ready,
  input logic        use_valid
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r3_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFF_BITS-1:0] == '0);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r8_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r2_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> $past(req_valid && req_ready, 2));

  a_r10_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r7_use_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    use_valid |-> resp_valid && !req_valid || resp_valid);
endmodule

bind sa_read_cache sa_read_cache_checker #(.OFF_BITS(OFF_BITS)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready), .use_valid(use_valid)
);

// File: tb/test_sa_read_cache.sv
module test_sa_read_cache;
  localparam int WAYS = 4, SET_BITS = 2, OFF_BITS = 3, WAY_W = 2;
  localparam int SETS = 1 << SET_BITS;
  localparam int WPB  = 1 << (OFF_BITS - 2);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mem_req_ready = 0, mem_resp_valid = 0;
  logic [31:0] req_addr = 0, mem_resp_data = 0;
  logic [WAY_W-1:0] repl_way = 0;
  logic req_ready, resp_valid, resp_hit, mem_req_valid, use_valid;
  logic [31:0] resp_data, mem_req_addr;
  logic [SET_BITS-1:0] query_set, use_set;
  logic [WAY_W-1:0] use_way;

  int checks = 0, failures = 0;
  bit mv [SETS][WAYS];
  int mt [SETS][WAYS];

  always #2 clk = ~clk;

  sa_read_cache #(.WAYS(WAYS), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS)) i_sa_read_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .repl_way(repl_way), .query_set(query_set),
    .use_valid(use_valid), .use_set(use_set), .use_way(use_way));

  function automatic logic [31:0] memword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A3C_0F96;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [WAY_W-1:0] rw, output bit got_hit);
    int s, t, ew, cycles, widx, nreq;
    bit ehit, done, phase, lastw;
    logic [31:0] base;
    s = int'(a[OFF_BITS +: SET_BITS]);
    t = int'(a >> (OFF_BITS + SET_BITS));
    base = {a[31:OFF_BITS], {OFF_BITS{1'b0}}};
    ehit = 0; ew = -1;
    for (int w = 0; w < WAYS; w++) if (ew < 0 && mv[s][w] && mt[s][w] == t) begin ehit = 1; ew = w; end
    if (!ehit) begin
      for (int w = WAYS - 1; w >= 0; w--) if (!mv[s][w]) ew = w;
      if (ew < 0) ew = int'(rw);
    end
    chk(req_ready, "R8 ready when idle", 32'(req_ready), 1);
    req_valid = 1; req_addr = a; repl_way = rw;
    @(negedge clk);
    req_valid = 0;
    cycles = 0; done = 0; phase = 0; widx = 0; nreq = 0; lastw = 0; got_hit = 0;
    while (!done && cycles < 60) begin
      mem_req_ready = 0;
      if (resp_valid) begin
        got_hit = resp_hit;
        chk(resp_hit == ehit, "R2 hit flag", 32'(resp_hit), 32'(ehit));
        chk(resp_data == memword({a[31:2], 2'b00}), "R10 response data", resp_data, memword({a[31:2], 2'b00}));
        chk(use_valid && int'(use_set) == s && int'(use_way) == ew, "R7 use report way",
            {use_valid, 15'd0, 14'(use_set), 2'(use_way)}, {1'b1, 15'd0, 14'(s), 2'(ew)});
        if (ehit) begin
          chk(cycles == 1 && nreq == 0, "R2 hit latency and no memory read", cycles, 1);
        end else begin
          chk(nreq == 1 && widx == WPB, "R4 one read, full block", nreq * 16 + widx, 16 + WPB);
          chk(lastw, "R10 response follows last word", 32'(lastw), 1);
        end
        done = 1;
      end else begin
        lastw = 0;
        mem_resp_valid = 0;
        if (mem_req_valid && !phase) begin
          chk(mem_req_addr == base, "R3 aligned block address", mem_req_addr, base);
          chk(int'(query_set) == s, "R6 query set", 32'(query_set), s);
          if ($urandom % 2 == 0) begin mem_req_ready = 1; phase = 1; nreq++; end
        end else if (phase && widx < WPB) begin
          if ($urandom % 4 != 0) begin
            mem_resp_valid = 1;
            mem_resp_data = memword(base + 32'(4 * widx));
            widx++;
            if (widx == WPB) lastw = 1;
          end
        end
      end
      if (!done) begin @(negedge clk); cycles++; end
    end
    mem_resp_valid = 0; mem_req_ready = 0;
    if (!done) chk(0, "R2 response timeout", cycles, 0);
    mv[s][ew] = 1; mt[s][ew] = t;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    bit h;
    bit exp_seq [5] = '{0, 1, 0, 0, 1};
    logic [31:0] seq [5] = '{32'd4, 32'd0, 32'd8, 32'd36, 32'd0};
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid && !use_valid, "R8 reset state",
        {req_ready, resp_valid, mem_req_valid, use_valid}, 4'b1000);

    for (int i = 0; i < 5; i++) begin
      access(seq[i], 2'd3, h);
      chk(h == exp_seq[i], "R9 sequence hit pattern", 32'(h), 32'(exp_seq[i]));
    end
    chk(mv[0][1] && mt[0][1] == 1, "R9 block of 36 in way 1", 32'(mt[0][1]), 1);
    access(32'd12, 2'd0, h);
    chk(h, "R4 other word of refilled block hits", 32'(h), 1);
    access(32'd68, 2'd0, h);
    chk(!h && mt[0][2] == 2, "R5 lowest invalid way used", 32'(mt[0][2]), 2);
    access(32'd100, 2'd0, h);
    chk(!h && mt[0][3] == 3, "R5 last invalid way used", 32'(mt[0][3]), 3);
    access(32'd132, 2'd1, h);
    chk(!h && mt[0][1] == 4, "R6 victim from repl_way", 32'(mt[0][1]), 4);
    access(32'd36, 2'd2, h);
    chk(!h, "R6 evicted block misses", 32'(h), 0);
    access(32'd4, 2'd2, h);
    chk(h, "R5 way 0 kept intact", 32'(h), 1);
    access({27'd5, 2'd3, 3'd4}, 2'd0, h);
    chk(!h, "R1 set 3 cold miss", 32'(h), 0);
    access({27'd5, 2'd2, 3'd4}, 2'd0, h);
    chk(!h, "R1 same tag other set misses", 32'(h), 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = {27'($urandom % 7), 2'($urandom % 2 == 0 ? 0 : $urandom % 4), 1'($urandom % 2), 2'b00};
      access(a, 2'($urandom % 4), h);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule